// File: doc/BRIEF.md
# MSI Address Composer

This block turns a pending, enabled interrupt source into a message-signalled interrupt write. For the chosen source it reads the source's target word, which holds a hart index, a guest index and a message identity. It splits the hart index into a group number and a local hart number. It places both, together with the guest index, at programmable bit offsets inside a page number built on a configured base page. The result is a 64-bit byte address and a 32-bit data word, offered on a valid/ready handshake.

Software programs two address-configuration words. The low word carries the low 32 bits of the base page number. The high word carries the upper base-page bits, four geometry fields and a lock bit that freezes both words once it is set. A software generate register can also inject a single message for an arbitrary hart and identity. The bus write itself, and the interrupt file that receives it, sit outside this block.

A message is taken from the source side only while the domain is enabled and the source is both enabled and pending. The source's pending flag is cleared in the same cycle that its message is loaded into the output stage.

Top module: `msi_addr_composer`

## Requirements
- R1: After a synchronous active-low reset, `msg_valid` is 0 and both configuration words read 0.
- R2: A write to the high configuration word (`cfg_sel`=1) keeps only the lock bit 31, the group shift at bits 28:24 (5 bits), the local hart shift at bits 22:20 (3 bits), the group width at bits 18:16 (3 bits), the local hart width at bits 15:12 (4 bits) and the upper base-page bits at 11:0; all other bits read back 0 (mask 0x9F77FFFF).
- R3: While bit 31 of the high configuration word is set, writes to the low word (`cfg_sel`=0) and to the high word are ignored.
- R4: The address is the page number shifted left by 12. The page number is the OR of four terms:
  - the base page, which is {high word bits 11:0, low word};
  - the group index (hart index >> local hart width), masked to the group width and shifted left by group shift + 12;
  - the local hart index (the low bits of the hart index, as many as the local hart width), shifted left by the local hart shift;
  - the guest index, masked to as many low bits as the local hart shift.
- R5: A source target word holds the hart index at bits 31:18, the guest index at 17:12 and the identity at 10:0; `msg_data` is the identity zero-extended to 32 bits.
- R6: With parameter MACHINE_LEVEL=1, the guest index is taken as zero for every message.
- R7: A source request is issued only when `dom_en` is 1 and the source's `src_en` bit is 1; a request that is blocked stays pending and is issued once both are set.
- R8: Each trigger pulse yields exactly one message: pending is cleared when that source's message is loaded into the output stage.
- R9: A write with `cfg_sel`=2 issues one message with hart index `cfg_wdata[31:18]`, identity `cfg_wdata[10:0]` and guest index 0. It does not depend on `dom_en` or on the lock, and it is served before any waiting source.
- R10: Several pending sources are issued in ascending source index order, one per accepted handshake.
- R11: While `msg_valid` is 1 and `msg_ready` is 0, the valid, address and data outputs hold their values.
- R12: A trigger pulse seen on one clock edge, with the output stage empty, shows up as `msg_valid` after the following edge (two edges from the pulse).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dom_en | input | 1 | Domain-wide enable for source messages |
| src_trig | input | NUM_SRC | One-cycle pulses that set each source's pending flag |
| src_en | input | NUM_SRC | Per-source enable |
| src_target | input | NUM_SRC*32 | Target words, source i at bits 32*i+31:32*i |
| cfg_we | input | 1 | Configuration or generate write strobe |
| cfg_sel | input | 2 | 0 low address word, 1 high address word, 2 generate |
| cfg_wdata | input | 32 | Write data |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_valid | output | 1 | Message available |
| msg_addr | output | 64 | Message byte address |
| msg_data | output | 32 | Message data word |
| cfg_lo_o | output | 32 | Current low configuration word |
| cfg_hi_o | output | 32 | Current high configuration word |

## Verification
The bound checker watches four properties on every cycle:
- the output holds steady under back-pressure;
- the locked configuration never changes;
- the undefined high-word bits stay zero and the upper data bits stay zero;
- the arbiter grants at most one source, never a disabled one and never while the domain is off.

The address arithmetic for several geometries, the ascending service order, the priority of generate writes, the one-message-per-trigger rule, the retention of blocked requests and the machine-level guest suppression depend on stimulus history. These are shown only by the bench's scenarios, which compare against a bit-by-bit reference model.

// File: rtl/msi_pkg.sv
// Package: shared constants and types for the MSI address composer.
// Assumes 32-bit configuration words and the field layout given in the brief.
package msi_pkg;

    // Write selector encodings on cfg_sel.
    localparam logic [1:0] SEL_LO  = 2'd0;
    localparam logic [1:0] SEL_HI  = 2'd1;
    localparam logic [1:0] SEL_GEN = 2'd2;

    // Bits of the high configuration word that software can set.
    localparam logic [31:0] HI_WR_MASK = 32'h9F77_FFFF;
    localparam int          LOCK_BIT   = 31;

    // Target word field widths.
    localparam int HART_W  = 14;
    localparam int GUEST_W = 6;
    localparam int EIID_W  = 11;

    // Page offset width of the final byte address.
    localparam int PAGE_SHIFT = 12;

    // Geometry carried by the high configuration word.
    typedef struct packed {
        logic [4:0] grp_shift;
        logic [2:0] hart_shift;
        logic [2:0] grp_width;
        logic [3:0] hart_width;
    } msi_geom_t;

endpackage

// File: rtl/msi_cfg_regs.sv
// Module: holds the two address-configuration words.
// The high word is masked to its defined fields on write. Once its lock bit is
// set, both words ignore writes until reset. Generate writes (SEL_GEN) never
// touch these words.
module msi_cfg_regs
    import msi_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    output logic [31:0] cfg_lo,
    output logic [31:0] cfg_hi
);

    logic locked;
    assign locked = cfg_hi[LOCK_BIT];

    // Update the configuration words on unlocked writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_lo <= '0;
            cfg_hi <= '0;
        end else if (wr_en && !locked) begin
            if (wr_sel == SEL_LO) begin
                cfg_lo <= wr_data;
            end else if (wr_sel == SEL_HI) begin
                cfg_hi <= wr_data & HI_WR_MASK;
            end
        end
    end

endmodule

// File: rtl/msi_addr_pack.sv
// Module: combinational packing of hart, guest and base page into a byte address.
// Assumes the geometry values are already extracted. Shift amounts are bounded
// by the field widths, so every term fits inside 64 bits.
module msi_addr_pack
    import msi_pkg::*;
(
    input  logic [31:0]        base_lo,
    input  logic [11:0]        base_hi,
    input  msi_geom_t          geom,
    input  logic [HART_W-1:0]  hart,
    input  logic [GUEST_W-1:0] guest,
    output logic [63:0]        addr
);

    logic [63:0] base_term;
    logic [63:0] grp_term;
    logic [63:0] hart_term;
    logic [63:0] guest_term;
    logic [63:0] hart_wide;
    logic [63:0] grp_idx;
    logic [6:0]  grp_pos;
    logic [63:0] page;

    // Form the four page-number terms and combine them.
    always_comb begin
        hart_wide  = {{(64-HART_W){1'b0}}, hart};
        base_term  = {20'b0, base_hi, base_lo};
        grp_idx    = (hart_wide >> geom.hart_width) &
                     ((64'd1 << geom.grp_width) - 64'd1);
        grp_pos    = {2'b0, geom.grp_shift} + 7'd12;
        grp_term   = grp_idx << grp_pos;
        hart_term  = (hart_wide & ((64'd1 << geom.hart_width) - 64'd1))
                     << geom.hart_shift;
        guest_term = {{(64-GUEST_W){1'b0}}, guest} &
                     ((64'd1 << geom.hart_shift) - 64'd1);
        page       = base_term | grp_term | hart_term | guest_term;
        addr       = page << PAGE_SHIFT;
    end

endmodule

// File: rtl/msi_src_arb.sv
// Module: per-source pending flags and a fixed ascending-priority pick.
// A source is eligible when it is pending, enabled and the domain is enabled.
// The chosen source's flag clears when take is high. A trigger in the same
// cycle sets the flag again.
module msi_src_arb #(
    parameter int NUM_SRC = 8,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] trig,
    input  logic [NUM_SRC-1:0] en,
    input  logic               dom_en,
    input  logic               take,
    output logic               any,
    output logic [IDX_W-1:0]   idx,
    output logic [NUM_SRC-1:0] grant
);

    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] eligible;
    logic [NUM_SRC-1:0] pick;

    assign eligible = pend & en & {NUM_SRC{dom_en}};

    // Lowest-index eligible source wins.
    always_comb begin
        any  = 1'b0;
        idx  = '0;
        pick = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                any  = 1'b1;
                idx  = IDX_W'(i);
                pick = NUM_SRC'(1) << i;
            end
        end
    end

    assign grant = take ? pick : '0;

    // Set pending on triggers, clear it on the granted source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            pend <= (pend & ~grant) | trig;
        end
    end

endmodule

// File: rtl/msi_addr_composer.sv
// Module: top of the MSI address composer.
// Chooses the next request (a generate write first, then the lowest eligible
// source), packs its address and data, and holds them in a one-entry output
// stage. The stage stays stable until msg_ready is seen.
// Assumes NUM_SRC >= 2 and that src_target is stable while a source is pending.
module msi_addr_composer
    import msi_pkg::*;
#(
    parameter int NUM_SRC       = 8,
    parameter int MACHINE_LEVEL = 0,
    localparam int IDX_W        = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  dom_en,
    input  logic [NUM_SRC-1:0]    src_trig,
    input  logic [NUM_SRC-1:0]    src_en,
    input  logic [NUM_SRC*32-1:0] src_target,
    input  logic                  cfg_we,
    input  logic [1:0]            cfg_sel,
    input  logic [31:0]           cfg_wdata,
    input  logic                  msg_ready,
    output logic                  msg_valid,
    output logic [63:0]           msg_addr,
    output logic [31:0]           msg_data,
    output logic [31:0]           cfg_lo_o,
    output logic [31:0]           cfg_hi_o
);

    logic [31:0]        cfg_lo;
    logic [31:0]        cfg_hi;
    msi_geom_t          geom;
    logic               arb_any;
    logic [IDX_W-1:0]   arb_idx;
    logic [NUM_SRC-1:0] arb_grant;
    logic               load;
    logic               src_take;
    logic               gen_wr;
    logic               gen_pend;
    logic [HART_W-1:0]  gen_hart;
    logic [EIID_W-1:0]  gen_eiid;
    logic [31:0]        sel_tgt;
    logic [GUEST_W-1:0] src_guest;
    logic [HART_W-1:0]  nxt_hart;
    logic [GUEST_W-1:0] nxt_guest;
    logic [EIID_W-1:0]  nxt_eiid;
    logic [63:0]        nxt_addr;
    logic               unused_guest;
    logic               unused_bits;

    // Configuration words.
    msi_cfg_regs u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_sel  (cfg_sel),
        .wr_data (cfg_wdata),
        .cfg_lo  (cfg_lo),
        .cfg_hi  (cfg_hi)
    );

    assign cfg_lo_o = cfg_lo;
    assign cfg_hi_o = cfg_hi;

    // Geometry field extraction from the high word.
    assign geom.grp_shift  = cfg_hi[28:24];
    assign geom.hart_shift = cfg_hi[22:20];
    assign geom.grp_width  = cfg_hi[18:16];
    assign geom.hart_width = cfg_hi[15:12];

    // The output stage can take a new entry when empty or being drained.
    assign load     = !msg_valid || msg_ready;
    assign src_take = load && !gen_pend && arb_any;

    // Source pending flags and priority pick.
    msi_src_arb #(.NUM_SRC(NUM_SRC)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig   (src_trig),
        .en     (src_en),
        .dom_en (dom_en),
        .take   (src_take),
        .any    (arb_any),
        .idx    (arb_idx),
        .grant  (arb_grant)
    );

    // Target word of the chosen source.
    assign sel_tgt = src_target[{arb_idx, 5'b0} +: 32];

    // A machine-level domain drops the guest index; otherwise take it from the target.
    generate
        if (MACHINE_LEVEL != 0) begin : g_mlvl
            assign src_guest    = '0;
            assign unused_guest = ^sel_tgt[17:12];
        end else begin : g_slvl
            assign src_guest    = sel_tgt[17:12];
            assign unused_guest = 1'b0;
        end
    endgenerate

    assign unused_bits = ^{unused_guest, sel_tgt[11], cfg_hi[31:29],
                           cfg_hi[23], cfg_hi[19], arb_grant};

    // Generate-register request capture; served ahead of sources.
    assign gen_wr = cfg_we && (cfg_sel == SEL_GEN);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_pend <= 1'b0;
            gen_hart <= '0;
            gen_eiid <= '0;
        end else begin
            gen_pend <= gen_wr || (gen_pend && !load);
            if (gen_wr) begin
                gen_hart <= cfg_wdata[31:18];
                gen_eiid <= cfg_wdata[EIID_W-1:0];
            end
        end
    end

    // Fields of the request being loaded next.
    assign nxt_hart  = gen_pend ? gen_hart : sel_tgt[31:18];
    assign nxt_guest = gen_pend ? '0       : src_guest;
    assign nxt_eiid  = gen_pend ? gen_eiid : sel_tgt[EIID_W-1:0];

    // Address packing.
    msi_addr_pack u_pack (
        .base_lo (cfg_lo),
        .base_hi (cfg_hi[11:0]),
        .geom    (geom),
        .hart    (nxt_hart),
        .guest   (nxt_guest),
        .addr    (nxt_addr)
    );

    // Output stage: loads when free, holds under back-pressure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid <= 1'b0;
            msg_addr  <= '0;
            msg_data  <= '0;
        end else if (load) begin
            msg_valid <= gen_pend || arb_any;
            if (gen_pend || arb_any) begin
                msg_addr <= nxt_addr;
                msg_data <= {{(32-EIID_W){1'b0}}, nxt_eiid};
            end
        end
    end

endmodule

// File: rtl/msi_addr_composer_chk.sv
// Module: assertion checker bound to every msi_addr_composer instance.
// Observes ports and the arbiter grant; drives nothing.
module msi_addr_composer_chk #(
    parameter int NUM_SRC = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               dom_en,
    input logic [NUM_SRC-1:0] src_en,
    input logic               msg_ready,
    input logic               msg_valid,
    input logic [63:0]        msg_addr,
    input logic [31:0]        msg_data,
    input logic [31:0]        cfg_lo_o,
    input logic [31:0]        cfg_hi_o,
    input logic [NUM_SRC-1:0] arb_grant
);

    // R1: the cycle after reset shows an empty stage and cleared configuration.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (!msg_valid && cfg_hi_o == 32'h0 && cfg_lo_o == 32'h0));

    // R2: undefined high-word bits never become set.
    assert_hi_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_hi_o & ~32'h9F77_FFFF) == 32'h0);

    // R3: once locked, both configuration words stay unchanged.
    assert_lock_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_hi_o[31] |=> ($stable(cfg_hi_o) && $stable(cfg_lo_o)));

    // R5: data carries only the 11-bit identity.
    assert_data_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_data[31:11] == 21'h0));

    // R7: no source is granted while the domain or that source is disabled.
    assert_grant_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|arb_grant) |-> (dom_en && ((arb_grant & ~src_en) == '0)));

    // R10: at most one source is granted per cycle.
    assert_single_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(arb_grant));

    // R11: the output holds under back-pressure.
    assert_hold_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=>
            (msg_valid && $stable(msg_addr) && $stable(msg_data)));

endmodule

bind msi_addr_composer msi_addr_composer_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dom_en    (dom_en),
    .src_en    (src_en),
    .msg_ready (msg_ready),
    .msg_valid (msg_valid),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data),
    .cfg_lo_o  (cfg_lo_o),
    .cfg_hi_o  (cfg_hi_o),
    .arb_grant (arb_grant)
);

// File: tb/msi_addr_composer_tb.sv
`timescale 1ns/1ps
// Bench: vector table for address packing, then directed scenarios.
module msi_addr_composer_tb;

    localparam int NS = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dom_en = 1'b1;
    logic [NS-1:0] src_trig = '0;
    logic [NS-1:0] src_en = '1;
    logic [NS*32-1:0] src_target = '0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = 2'd3;
    logic [31:0]   cfg_wdata = '0;
    logic          msg_ready = 1'b0;
    logic          msg_valid, msg_valid_m;
    logic [63:0]   msg_addr, msg_addr_m;
    logic [31:0]   msg_data, msg_data_m;
    logic [31:0]   cfg_lo_o, cfg_hi_o, cfg_lo_m, cfg_hi_m;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    msi_addr_composer #(.NUM_SRC(NS), .MACHINE_LEVEL(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .dom_en(dom_en), .src_trig(src_trig),
        .src_en(src_en), .src_target(src_target), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .msg_ready(msg_ready),
        .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data),
        .cfg_lo_o(cfg_lo_o), .cfg_hi_o(cfg_hi_o));

    msi_addr_composer #(.NUM_SRC(NS), .MACHINE_LEVEL(1)) u_dut_m (
        .clk(clk), .rst_n(rst_n), .dom_en(dom_en), .src_trig(src_trig),
        .src_en(src_en), .src_target(src_target), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .msg_ready(msg_ready),
        .msg_valid(msg_valid_m), .msg_addr(msg_addr_m), .msg_data(msg_data_m),
        .cfg_lo_o(cfg_lo_m), .cfg_hi_o(cfg_hi_m));

    // Stimulus table: low word, high word, target word of source 0.
    localparam logic [31:0] V_LO  [4] = '{32'h0008_0000, 32'h0001_2345,
                                         32'hFFFF_F000, 32'h0000_0100};
    localparam logic [31:0] V_HI  [4] = '{32'h0000_0000, 32'h0413_200A,
                                         32'h0A32_4FFF, 32'h1F77_0000};
    localparam logic [31:0] V_TGT [4] = '{32'h000C_0005, 32'h0074_17FF,
                                         32'hFFFF_F123, 32'h0156_A040};

    // Bit-level reference model of the address rule (R4).
    function automatic logic [63:0] ref_addr(input logic [31:0] lo,
            input logic [31:0] hi, input logic [13:0] hart, input logic [5:0] guest);
        logic [63:0] p;
        logic [13:0] grp;
        int lw, hw, ls, hs;
        lw = int'(hi[15:12]); hw = int'(hi[18:16]);
        ls = int'(hi[22:20]); hs = int'(hi[28:24]);
        p = {20'b0, hi[11:0], lo};
        grp = hart >> lw;
        for (int b = 0; b < hw; b++) if (b < 14 && grp[b]) p[b + hs + 12] = 1'b1;
        for (int b = 0; b < lw; b++) if (b < 14 && hart[b]) p[b + ls] = 1'b1;
        for (int b = 0; b < ls; b++) if (b < 6 && guest[b]) p[b] = 1'b1;
        return p << 12;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_sel = 2'd3;
    endtask

    task automatic pulse(input logic [NS-1:0] m);
        @(negedge clk);
        src_trig = m;
        @(negedge clk);
        src_trig = '0;
    endtask

    task automatic wait_valid(output bit got);
        got = 1'b0;
        for (int k = 0; k < 20; k++) begin
            if (msg_valid) begin got = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic accept();
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic idle_check(input string req, input int n);
        bit seen;
        seen = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (msg_valid) seen = 1'b1;
        end
        check(req, 64'(seen), 64'd0);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        bit got;
        logic [63:0] a0;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 valid", 64'(msg_valid), 64'd0);
        check("R1 cfg_hi", 64'(cfg_hi_o), 64'd0);
        check("R1 cfg_lo", 64'(cfg_lo_o), 64'd0);
        rst_n = 1'b1;

        // R4/R5/R6 vector table on source 0.
        for (int v = 0; v < 4; v++) begin
            cfg_write(2'd0, V_LO[v]);
            cfg_write(2'd1, V_HI[v]);
            src_target[31:0] = V_TGT[v];
            msg_ready = 1'b0;
            @(negedge clk);
            src_trig = 8'h01;
            @(negedge clk);
            src_trig = '0;
            if (v == 0) check("R12 not yet valid", 64'(msg_valid), 64'd0);
            @(negedge clk);
            if (v == 0) check("R12 valid after two edges", 64'(msg_valid), 64'd1);
            wait_valid(got);
            check("R4 address", msg_addr,
                  ref_addr(V_LO[v], V_HI[v], V_TGT[v][31:18], V_TGT[v][17:12]));
            check("R5 data", 64'(msg_data), {53'b0, V_TGT[v][10:0]});
            check("R6 guest zero at machine level", msg_addr_m,
                  ref_addr(V_LO[v], V_HI[v], V_TGT[v][31:18], 6'd0));
            accept();
        end

        // Distinct identity per source for ordering scenarios.
        for (int i = 0; i < NS; i++) src_target[i*32 +: 32] = (i << 18) | (32'h10 + i);

        // R10/R11: ascending order, held under back-pressure; R8 one message each.
        pulse(8'b0110_0100);
        wait_valid(got);
        check("R10 first", 64'(msg_data), 64'h12);
        a0 = msg_addr;
        repeat (3) @(negedge clk);
        check("R11 held valid", 64'(msg_valid), 64'd1);
        check("R11 held addr", msg_addr, a0);
        check("R11 held data", 64'(msg_data), 64'h12);
        accept();
        check("R10 second", 64'(msg_data), 64'h15);
        accept();
        check("R10 third", 64'(msg_data), 64'h16);
        accept();
        idle_check("R8 no repeat", 6);

        // R7: domain disabled keeps request pending.
        dom_en = 1'b0;
        pulse(8'b0000_1000);
        idle_check("R7 domain off", 5);
        dom_en = 1'b1;
        wait_valid(got);
        check("R7 retained after domain enable", 64'(msg_data), 64'h13);
        accept();

        // R7: source disabled keeps request pending.
        src_en[4] = 1'b0;
        pulse(8'b0001_0000);
        idle_check("R7 source off", 5);
        src_en[4] = 1'b1;
        wait_valid(got);
        check("R7 retained after source enable", 64'(msg_data), 64'h14);
        accept();

        // R9: generate write served before a waiting source, guest forced zero.
        pulse(8'b1000_0000);
        wait_valid(got);
        check("R9 occupy stage", 64'(msg_data), 64'h17);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'd2;
        cfg_wdata = (32'd9 << 18) | (32'h3F << 12) | 32'h2AB;
        src_trig = 8'b0000_0010;
        @(negedge clk);
        cfg_we = 1'b0; cfg_sel = 2'd3; src_trig = '0;
        @(negedge clk);
        accept();
        check("R9 generate first", 64'(msg_data), 64'h2AB);
        check("R9 generate address", msg_addr, ref_addr(cfg_lo_o, cfg_hi_o, 14'd9, 6'd0));
        accept();
        check("R9 source after generate", 64'(msg_data), 64'h11);
        accept();

        // R9: generate ignores domain enable.
        dom_en = 1'b0;
        cfg_write(2'd2, (32'd2 << 18) | 32'h055);
        wait_valid(got);
        check("R9 generate with domain off", 64'(msg_data), 64'h055);
        accept();
        dom_en = 1'b1;

        // R2/R3: mask on high write, then lock freezes both words.
        cfg_write(2'd0, 32'h0000_1111);
        cfg_write(2'd1, 32'hFFFF_FFFF);
        check("R2 high mask", 64'(cfg_hi_o), 64'h9F77_FFFF);
        cfg_write(2'd0, 32'h0000_2222);
        cfg_write(2'd1, 32'h0000_0000);
        check("R3 low locked", 64'(cfg_lo_o), 64'h1111);
        check("R3 high locked", 64'(cfg_hi_o), 64'h9F77_FFFF);

        // R1: reset clears lock and configuration.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 cfg_hi after reset", 64'(cfg_hi_o), 64'd0);
        check("R1 valid after reset", 64'(msg_valid), 64'd0);
        rst_n = 1'b1;
        cfg_write(2'd0, 32'h0000_3333);
        check("R3 unlocked after reset", 64'(cfg_lo_o), 64'h3333);

        summary();
    end

endmodule